// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block arbitrates a parameterized set of external interrupt lines (eight by default) on behalf of a small processor core model. Each line has an enable bit, a pending bit, an active bit and an 8-bit priority byte. A control field splits every priority byte into an upper preemption group and a lower subpriority. Every cycle the block finds the most urgent pending and enabled line. It then tells the core to enter that line's handler, provided the global mask input is low and the line's group is strictly more urgent than the group of every handler already running.

The core answers a request with an entry acknowledge, which moves the line from pending to active. Later it reports the handler's end with an exit strobe and the vector number, which clears the active bit. Software reaches the state through a simple word-addressed register bus with a one-cycle read latency. A packed status word reports the pending vector and the active vector. Vector numbers are the line index plus 16.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable, pending, active, priority, status and control registers all read 0, and `take_req` is 0.
- R2: The enable register at 0x100 is read/write, with bit i belonging to line i. A line whose enable bit is 0 keeps its pending bit but is never requested. It also does not count toward status bit 22 or status bits 20:12.
- R3: Writing the set-pending register at 0x200 marks pending every line whose data bit is 1, and bits written as 0 have no effect. A cycle with `irq_in[i]` high also marks line i pending. Reading 0x200 returns the pending bits.
- R4: When `take_ack` is high while `take_req` is high, the line named by `take_vec` is entered: its pending bit clears and its active bit sets, and `take_req` is 0 in the following cycle. An `exit_ack` with `exit_vec` in 16..16+N-1 clears the active bit of line `exit_vec`-16. An `exit_vec` outside that range has no effect. The active register at 0x300 reads back the active bits.
- R5: While `glob_mask` is high, `take_req` stays 0. When `glob_mask` is released, an eligible line is requested within two cycles.
- R6: The line requested, and the vector reported in status bits 20:12, is the pending enabled line with the numerically lowest priority byte, with ties going to the lowest line index. `take_vec` equals the line index plus 16.
- R7: A request is raised only when the chosen line's group value is strictly below the best group value among active lines. When no line is active, any eligible line qualifies. An equal or worse group waits until the running handlers exit.
- R8: The group setting G is held in bits 10:8 of the control register at 0xD0C. A write changes it only when data bits 31:16 equal 0x05FA. A line's group value is its priority bits 7:G+1, so G = 7 disables all preemption.
- R9: The status word at 0xD04 holds four fields; all its other bits are 0:
  - bit 22 is set when any enabled line is pending;
  - bits 20:12 hold the vector chosen under R6, or 0 when no line is chosen;
  - bit 11 is set when exactly one line is active;
  - bits 8:0 hold the vector of the active line with the lowest priority byte (lowest index on ties), or 0 when none is active.
- R10: Priority byte for line i is stored at address 0x400 + 4*(i/4), data bits 8*(i%4)+7 : 8*(i%4), and reads back from the same place.
- R11: `bus_rdata` presents the value addressed in the cycle `bus_rd` was high on the following cycle. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Per-line interrupt event; high marks the line pending |
| glob_mask | input | 1 | Global mask; high blocks all requests |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| take_req | output | 1 | Request to the core to enter a handler |
| take_vec | output | 9 | Vector to enter while `take_req` is high |
| take_ack | input | 1 | Core has entered the requested handler |
| exit_ack | input | 1 | Core has left the handler named by `exit_vec` |
| exit_vec | input | 9 | Vector of the handler that exits |

## Verification
The bench targets four orderings. The first is a same-group request arriving during a running handler: a design that preempts on equal group would request it at once instead of after the exit. The second is two pending lines in one group whose subpriorities differ, and the third is two lines with identical bytes. Picking by index alone, or by the highest index, shows up as the wrong `take_vec` in those cases. The fourth covers control writes with a bad key, group setting 7, disabled-but-pending lines, and irrelevant exit vectors, each of which would corrupt the state read back through the bus or the status word. A long random run of pends, priority rewrites, group changes, mask toggles, entries and exits is compared against a bench model after every step.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PRIO_W   = 8;
  localparam int GRP_W    = 3;
  localparam int VEC_W    = 9;
  localparam int VEC_BASE = 16;
  localparam int DW       = 32;

  localparam int OFS_EN   = 'h100;
  localparam int OFS_PEND = 'h200;
  localparam int OFS_ACT  = 'h300;
  localparam int OFS_PRIO = 'h400;
  localparam int OFS_STAT = 'hD04;
  localparam int OFS_CTRL = 'hD0C;

  localparam logic [15:0] CTRL_KEY = 16'h05FA;

  // Group value of a priority byte, left-aligned, with a spare top bit so
  // that the idle thread level (all ones above the byte) sorts last.
  function automatic logic [PRIO_W:0] grp_level(input logic [PRIO_W-1:0] p,
                                                input logic [GRP_W-1:0]  g);
    logic [PRIO_W-1:0] m;
    m = {PRIO_W{1'b1}} << ({1'b0, g} + 4'd1);
    return {1'b0, p & m};
  endfunction
endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   req,
  input  logic [N*W-1:0] keys,
  output logic           hit,
  output logic [IW-1:0]  idx,
  output logic [W-1:0]   key
);
  logic [W-1:0] best;

  // Lowest key wins; strict compare keeps the lowest index on ties.
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = {W{1'b1}};
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!hit || keys[i*W +: W] < best)) begin
        hit  = 1'b1;
        idx  = IW'(i);
        best = keys[i*W +: W];
      end
    end
  end

  assign key = best;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [N-1:0]      irq_in,
  input  logic              ent_vld,
  input  logic [IW-1:0]     ent_line,
  input  logic              ext_vld,
  input  logic [IW-1:0]     ext_line,
  input  logic [DW-1:0]     status_word,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      pend_q,
  output logic [N-1:0]      act_q,
  output logic [N*PRIO_W-1:0] prio_flat,
  output logic [GRP_W-1:0]  grp_q,
  output logic [DW-1:0]     rdata_q
);
  localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
  localparam logic [AW-1:0] A_PEND = AW'(OFS_PEND);
  localparam logic [AW-1:0] A_ACT  = AW'(OFS_ACT);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam int LANES = DW / PRIO_W;

  logic [PRIO_W-1:0] prio_q [N];
  logic [N-1:0] set_m, ent_m, ext_m;
  logic [DW-1:0] rd_nx;

  assign set_m = irq_in | ((bus_wr && bus_addr == A_PEND) ? bus_wdata[N-1:0] : '0);
  assign ent_m = ent_vld ? (N'(1) << ent_line) : '0;
  assign ext_m = ext_vld ? (N'(1) << ext_line) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      grp_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_EN) en_q <= bus_wdata[N-1:0];
      if (bus_wr && bus_addr == A_CTRL && bus_wdata[31:16] == CTRL_KEY)
        grp_q <= bus_wdata[10:8];
      pend_q <= (pend_q & ~ent_m) | set_m;
      act_q  <= (act_q | ent_m) & ~ext_m;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_prio
    localparam logic [AW-1:0] MY_ADDR = AW'(OFS_PRIO + 4 * (i / LANES));
    localparam int LANE = i % LANES;
    always_ff @(posedge clk) begin
      if (rst) prio_q[i] <= '0;
      else if (bus_wr && bus_addr == MY_ADDR)
        prio_q[i] <= bus_wdata[PRIO_W*LANE +: PRIO_W];
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  always_comb begin
    rd_nx = '0;
    if (bus_addr == A_EN)        rd_nx[N-1:0] = en_q;
    else if (bus_addr == A_PEND) rd_nx[N-1:0] = pend_q;
    else if (bus_addr == A_ACT)  rd_nx[N-1:0] = act_q;
    else if (bus_addr == A_STAT) rd_nx = status_word;
    else if (bus_addr == A_CTRL) rd_nx[10:8] = grp_q;
    else begin
      for (int i = 0; i < N; i++) begin
        if (bus_addr == AW'(OFS_PRIO + 4 * (i / LANES)))
          rd_nx[PRIO_W*(i % LANES) +: PRIO_W] = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_nx;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int AW      = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               glob_mask,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               take_req,
  output logic [8:0]         take_vec,
  input  logic               take_ack,
  input  logic               exit_ack,
  input  logic [8:0]         exit_vec
);
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam logic [VEC_W-1:0] V_LO = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] V_HI = VEC_W'(VEC_BASE + N_LINES);
  localparam logic [PRIO_W:0]  THREAD_LVL = {1'b1, {PRIO_W{1'b0}}};

  logic [N_LINES-1:0] en_q, pend_q, act_q;
  logic [N_LINES*PRIO_W-1:0] prio_flat;
  logic [GRP_W-1:0] grp_q;
  logic [DW-1:0] status_word;

  logic sel_hit, run_hit;
  logic [IW-1:0] sel_idx, run_idx;
  logic [PRIO_W-1:0] sel_key, run_key;
  logic [PRIO_W:0] sel_grp, exec_grp;
  logic cand;
  logic ent_vld, ext_vld;
  logic [IW-1:0] ent_line, ext_line;
  logic [VEC_W-1:0] sel_vec, run_vec, ext_off;
  logic one_active;

  irqc_regs #(.N(N_LINES), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq_in(irq_in),
    .ent_vld(ent_vld), .ent_line(ent_line),
    .ext_vld(ext_vld), .ext_line(ext_line),
    .status_word(status_word),
    .en_q(en_q), .pend_q(pend_q), .act_q(act_q),
    .prio_flat(prio_flat), .grp_q(grp_q), .rdata_q(bus_rdata)
  );

  irqc_pick #(.N(N_LINES), .W(PRIO_W)) u_pick_pend (
    .req(pend_q & en_q), .keys(prio_flat),
    .hit(sel_hit), .idx(sel_idx), .key(sel_key)
  );

  irqc_pick #(.N(N_LINES), .W(PRIO_W)) u_pick_run (
    .req(act_q), .keys(prio_flat),
    .hit(run_hit), .idx(run_idx), .key(run_key)
  );

  assign sel_grp  = grp_level(sel_key, grp_q);
  assign exec_grp = run_hit ? grp_level(run_key, grp_q) : THREAD_LVL;
  assign cand     = sel_hit && !glob_mask && (sel_grp < exec_grp);
  assign sel_vec  = sel_hit ? V_LO + VEC_W'(sel_idx) : '0;
  assign run_vec  = run_hit ? V_LO + VEC_W'(run_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_req <= 1'b0;
      take_vec <= '0;
    end else begin
      take_req <= cand && !take_ack;
      take_vec <= cand ? sel_vec : '0;
    end
  end

  assign ent_vld  = take_ack && take_req;
  assign ent_line = IW'(take_vec - V_LO);
  assign ext_off  = exit_vec - V_LO;
  assign ext_vld  = exit_ack && exit_vec >= V_LO && exit_vec < V_HI;
  assign ext_line = IW'(ext_off);

  assign one_active = (act_q != '0) && ((act_q & (act_q - N_LINES'(1))) == '0);

  always_comb begin
    status_word        = '0;
    status_word[22]    = sel_hit;
    status_word[20:12] = sel_vec;
    status_word[11]    = one_active;
    status_word[8:0]   = run_vec;
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic         clk,
  input logic         rst,
  input logic         glob_mask,
  input logic         take_req,
  input logic [8:0]   take_vec,
  input logic         take_ack,
  input logic         exit_ack,
  input logic [8:0]   exit_vec,
  input logic [N-1:0] act_q
);
  logic [IW-1:0] tl, xl;
  logic x_in;
  assign tl   = IW'(take_vec - 9'd16);
  assign xl   = IW'(exit_vec - 9'd16);
  assign x_in = exit_vec >= 9'd16 && exit_vec < 9'(16 + N);

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    take_req |-> !$past(glob_mask));

  // R4
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    take_ack |=> !take_req);

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    take_req |-> (take_vec >= 9'd16 && take_vec < 9'(16 + N)));

  // R4
  entry_set_chk: assert property (@(posedge clk) disable iff (rst)
    (take_ack && take_req && !exit_ack) |=> act_q[$past(tl)]);

  // R4
  exit_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (exit_ack && x_in && !take_ack) |=> !act_q[$past(xl)]);
endmodule

bind prio_irq_ctrl irqc_chk #(.N(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .glob_mask(glob_mask),
  .take_req(take_req), .take_vec(take_vec), .take_ack(take_ack),
  .exit_ack(exit_ack), .exit_vec(exit_vec), .act_q(act_q)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int N  = 8;
  localparam int PW = (N + 3) / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0] irq_in = '0;
  logic glob_mask = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic take_req, take_ack = 1'b0, exit_ack = 1'b0;
  logic [8:0] take_vec, exit_vec = '0;

  prio_irq_ctrl #(.N_LINES(N), .AW(12)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .glob_mask(glob_mask),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .take_req(take_req), .take_vec(take_vec),
    .take_ack(take_ack), .exit_ack(exit_ack), .exit_vec(exit_vec)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the architectural state
  logic [N-1:0] m_en = '0, m_pend = '0, m_act = '0;
  logic [7:0] m_prio [N];
  int m_g = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_best(logic [N-1:0] m);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (b < 0 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  function automatic int m_grp(logic [7:0] p);
    return int'(p) >> (m_g + 1);
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    int sl = m_best(m_pend & m_en);
    int al = m_best(m_act);
    if (sl >= 0) begin s[22] = 1'b1; s[20:12] = 9'(sl + 16); end
    if ($countones(m_act) == 1) s[11] = 1'b1;
    if (al >= 0) s[8:0] = 9'(al + 16);
    return s;
  endfunction

  function automatic int m_take();  // line to request, -1 for none
    int sl = m_best(m_pend & m_en);
    int al = m_best(m_act);
    int ex = (al >= 0) ? m_grp(m_prio[al]) : 256;
    if (sl >= 0 && !glob_mask && m_grp(m_prio[sl]) < ex) return sl;
    return -1;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 12'h100) m_en = d[N-1:0];
    else if (a == 12'h200) m_pend = m_pend | d[N-1:0];
    else if (a == 12'hD0C) begin if (d[31:16] == 16'h05FA) m_g = int'(d[10:8]); end
    else if (a >= 12'h400 && a < 12'(12'h400 + 4 * PW) && a[1:0] == 2'b00) begin
      for (int b = 0; b < 4; b++) begin
        int ln = int'(a - 12'h400) + b;
        if (ln < N) m_prio[ln] = d[8*b +: 8];
      end
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_mask(logic v);
    @(negedge clk);
    glob_mask = v;
  endtask

  task automatic pulse(logic [N-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    irq_in = '0;
    m_pend = m_pend | v;
  endtask

  task automatic enter();
    int ln;
    @(negedge clk);
    take_ack = 1'b1;
    ln = int'(take_vec) - 16;
    @(negedge clk);
    take_ack = 1'b0;
    if (ln >= 0 && ln < N) begin m_pend[ln] = 1'b0; m_act[ln] = 1'b1; end
    chk("R4", "take_req after entry", 32'(take_req), 32'd0);
  endtask

  task automatic leave(int v);
    @(negedge clk);
    exit_ack = 1'b1; exit_vec = 9'(v);
    @(negedge clk);
    exit_ack = 1'b0;
    if (v >= 16 && v < 16 + N) m_act[v-16] = 1'b0;
  endtask

  task automatic expect_take(string req, logic r, int v);
    @(negedge clk);
    chk(req, "take_req", 32'(take_req), 32'(r));
    if (r) chk(req, "take_vec", 32'(take_vec), 32'(v));
  endtask

  task automatic expect_reg(string req, logic [11:0] a, logic [31:0] e);
    logic [31:0] d;
    rd(a, d);
    chk(req, $sformatf("reg %h", a), d, e);
  endtask

  task automatic verify(string req);
    int t;
    logic [31:0] d;
    @(negedge clk);
    t = m_take();
    chk(req, "model take_req", 32'(take_req), 32'(t >= 0));
    if (t >= 0) chk(req, "model take_vec", 32'(take_vec), 32'(t + 16));
    rd(12'hD04, d);
    chk("R9", "model status", d, m_status());
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] d;
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    expect_take("R1", 1'b0, 0);
    expect_reg("R1", 12'h100, 0);
    expect_reg("R1", 12'h200, 0);
    expect_reg("R1", 12'h300, 0);
    expect_reg("R1", 12'hD04, 0);
    expect_reg("R1", 12'hD0C, 0);
    expect_reg("R1", 12'h400, 0);

    // R5 masked pending line is not requested
    set_mask(1'b1);
    wr(12'h100, 32'h3);
    wr(12'h200, 32'h1);
    expect_take("R5", 1'b0, 0);
    expect_reg("R9", 12'hD04, 32'h0041_0000);
    expect_reg("R3", 12'h200, 32'h1);
    wr(12'h200, 32'h0);
    expect_reg("R3", 12'h200, 32'h1);
    expect_reg("R2", 12'h100, 32'h3);

    // R5 release; R6 vector = line + 16
    set_mask(1'b0);
    @(negedge clk);
    expect_take("R5", 1'b1, 16);
    enter();
    expect_reg("R9", 12'hD04, 32'h0000_0810);
    expect_reg("R4", 12'h300, 32'h1);
    expect_reg("R4", 12'h200, 32'h0);

    // R8 key gate
    wr(12'hD0C, 32'h0000_0500);
    expect_reg("R8", 12'hD0C, 32'h0);
    wr(12'hD0C, 32'h05FA_0500);
    expect_reg("R8", 12'hD0C, 32'h500);

    // R7 strictly better group preempts; R10 byte placement
    wr(12'h400, 32'h0000_4080);
    expect_reg("R10", 12'h400, 32'h0000_4080);
    wr(12'h200, 32'h2);
    expect_take("R7", 1'b1, 17);
    enter();
    expect_reg("R9", 12'hD04, 32'h0000_0011);
    leave(17);
    expect_reg("R9", 12'hD04, 32'h0000_0810);
    leave(16);
    expect_reg("R4", 12'h300, 32'h0);

    // R7 equal group does not preempt
    wr(12'h200, 32'h1);
    expect_take("R7", 1'b1, 16);
    enter();
    wr(12'h400, 32'h0000_9F80);
    wr(12'h200, 32'h2);
    expect_take("R7", 1'b0, 0);
    expect_reg("R9", 12'hD04, 32'h0041_1810);
    leave(16);
    @(negedge clk);
    expect_take("R7", 1'b1, 17);
    enter();
    leave(17);

    // R6 subpriority decides inside a group
    set_mask(1'b1);
    wr(12'h400, 32'h0000_003F);
    wr(12'h200, 32'h3);
    set_mask(1'b0);
    @(negedge clk);
    expect_take("R6", 1'b1, 17);
    enter();
    expect_take("R7", 1'b0, 0);
    leave(17);
    @(negedge clk);
    expect_take("R6", 1'b1, 16);
    enter();
    leave(16);

    // R6 identical bytes: lowest index first
    wr(12'h400, 32'h0);
    set_mask(1'b1);
    wr(12'h200, 32'h3);
    set_mask(1'b0);
    @(negedge clk);
    expect_take("R6", 1'b1, 16);
    enter();
    expect_take("R6", 1'b0, 0);
    leave(16);
    @(negedge clk);
    expect_take("R6", 1'b1, 17);
    enter();
    leave(17);

    // R2 disabled line stays pending but is excluded
    wr(12'h100, 32'h0);
    wr(12'h200, 32'h4);
    expect_take("R2", 1'b0, 0);
    expect_reg("R2", 12'hD04, 32'h0);
    expect_reg("R2", 12'h200, 32'h4);
    wr(12'h100, 32'h4);
    expect_take("R2", 1'b1, 18);
    enter();
    leave(18);

    // R8 group setting 7 disables preemption
    wr(12'hD0C, 32'h05FA_0700);
    wr(12'h100, 32'hFF);
    wr(12'h400, 32'h0000_0080);
    wr(12'h200, 32'h1);
    expect_take("R8", 1'b1, 16);
    enter();
    wr(12'h200, 32'h2);
    expect_take("R8", 1'b0, 0);
    leave(16);
    @(negedge clk);
    expect_take("R8", 1'b1, 17);
    enter();
    leave(17);

    // R3 line input; R4 out-of-range exit ignored
    pulse(8'h08);
    expect_take("R3", 1'b1, 19);
    enter();
    leave(5);
    expect_reg("R4", 12'h300, 32'h8);
    leave(19);
    expect_reg("R4", 12'h300, 32'h0);

    // R11 unmapped read
    expect_reg("R11", 12'h004, 32'h0);
    expect_reg("R11", 12'h500, 32'h0);
    verify("R6");

    // random phase against the model
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 9);
      case (op)
        0: wr(12'h200, 32'($urandom) & 32'($urandom));
        1: wr(12'h100, 32'($urandom) | 32'($urandom));
        2: begin
          logic [31:0] w;
          for (int b = 0; b < 4; b++)
            w[8*b +: 8] = 8'(($urandom % 4) * 64 + ($urandom % 2) * 32);
          wr(12'(12'h400 + 4 * ($urandom % PW)), w);
        end
        3: wr(12'hD0C, {(($urandom % 4) != 0) ? 16'h05FA : 16'h1234,
                        5'd0, 3'($urandom), 8'd0});
        4, 5: if (take_req) enter();
        6: begin
          if (m_act != '0) begin
            int ln;
            do ln = int'($urandom % N); while (!m_act[ln]);
            leave(ln + 16);
          end else leave(int'($urandom % 32));
        end
        7: begin
          pulse(N'($urandom) & N'($urandom));
          if (($urandom % 3) == 0) set_mask(~glob_mask);
        end
        default: begin
          int k = int'($urandom % PW);
          logic [31:0] e = '0;
          for (int b = 0; b < 4; b++) if (4*k + b < N) e[8*b +: 8] = m_prio[4*k + b];
          expect_reg("R10", 12'(12'h400 + 4*k), e);
          expect_reg("R3", 12'h200, 32'(m_pend));
          expect_reg("R4", 12'h300, 32'(m_act));
          expect_reg("R8", 12'hD0C, 32'(m_g) << 8);
        end
      endcase
      verify("R7");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule